// File: doc/BRIEF.md
# Video DMA Bus-Request Scheduler

This block asks the processor for its bus so that the display subsystem can fetch character and attribute data. Each character row is made of numbered scan lines. On two fixed scan lines of every row the block raises an active-low bus request. The processor finishes its current machine cycle and then answers with an active-low acknowledge. The request stays asserted until a programmed number of character fetches has completed while the bus was granted. The block then releases the request and waits for the processor to take its bus back.

While the grant is in force, the block turns the acknowledge into an active-high copy and an active-low copy. These copies stand in for the processor-side buffer disables and the video-side DMA enables. The DMA address is 16 bits wide. The active-high copy gates the lower 12 bits, which come from the display controller. The active-low copy gates the upper 4 bits, which come from a local page register. The same grant also takes the line buffer out of its recirculating mode, so that the buffer loads fresh data.

Top module: `vdma_bus_sched`

## Requirements
- R1: After reset, `bus_req_n` is 1, the block is idle, and the page register holds 0.
- R2: When `scan_line` (plain binary) changes to 6 or to 14, `bus_req_n` goes to 0 at the next rising clock edge. This happens only if no earlier request is still in progress.
- R3: `scan_line` values other than 6 and 14 raise no request. Holding `scan_line` at 6 or 14 for many cycles raises the request only once, when the value is entered.
- R4: `ack_hi` equals the inverse of `bus_ack_n` and `ack_lo_n` equals `bus_ack_n`, in the same cycle, with no register in the path.
- R5: `dma_addr[11:0]` equals `ctrl_addr` while `ack_hi` is 1, and is 0 otherwise.
- R6: `dma_addr[15:12]` equals the page register while `ack_lo_n` is 0, and is 0 otherwise. A rising edge with `upper_wr` at 1 loads `upper_din` into the page register.
- R7: `recirc` is 1 (line buffer recirculating) except while `bus_ack_n` is 0, when it is 0.
- R8: Once the bus is granted, `bus_req_n` stays 0 until `burst_len` `fetch_done` pulses have been counted. It returns to 1 at the clock edge that samples the last pulse. A `burst_len` of 0 behaves as 1.
- R9: `fetch_done` pulses seen before the grant arrives are not counted toward the burst.
- R10: A scan-line trigger is dropped without a second request if it arrives while a request is pending or while `bus_ack_n` is still 0 after a release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scan_line | input | 4 | Current scan line within the character row |
| burst_len | input | 8 | Number of character fetches per DMA burst |
| fetch_done | input | 1 | One-cycle pulse per completed character fetch |
| bus_ack_n | input | 1 | Active-low bus acknowledge from the processor |
| ctrl_addr | input | 12 | Lower DMA address from the display controller |
| upper_wr | input | 1 | Load strobe for the page register |
| upper_din | input | 4 | Page register load value |
| bus_req_n | output | 1 | Active-low bus request to the processor |
| ack_hi | output | 1 | Active-high acknowledge copy (lower-address enable, CPU buffer disable) |
| ack_lo_n | output | 1 | Active-low acknowledge copy (upper-address enable) |
| recirc | output | 1 | Line buffer recirculate mode |
| dma_addr | output | 16 | Assembled DMA address, zero when not driven |

## Verification
The bench holds a trigger line for many cycles. A design that detects the level instead of the change of line would re-request after every release. It sends fetch pulses before the grant arrives. A design that counts them would drop the request one fetch early. It presents line 14 while the processor still holds the acknowledge after a release. A design without that guard would issue an overlapping request. Zero-length bursts and unwritten page bits are also checked, which catches a counter that wraps and a page register that resets to the wrong value.

// File: rtl/vdma_pkg.sv
package vdma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_OWN  = 2'd2,
    ST_DROP = 2'd3
  } sched_st_e;

endpackage

// File: rtl/vdma_line_trig.sv
module vdma_line_trig #(
  parameter int LINE_W = 4,
  parameter int LINE_A = 6,
  parameter int LINE_B = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] scan_line,
  output logic              trig
);

  localparam logic [LINE_W-1:0] HIT_A = LINE_A[LINE_W-1:0];
  localparam logic [LINE_W-1:0] HIT_B = LINE_B[LINE_W-1:0];

  logic [LINE_W-1:0] prev_q, prev_d;
  logic              is_hit, changed;

  always_comb begin
    prev_d  = scan_line;
    changed = (scan_line != prev_q);
    is_hit  = (scan_line == HIT_A) || (scan_line == HIT_B);
    trig    = changed && is_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  // a held hit line must not fire twice in a row
  assert_no_repeat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !trig);

endmodule

// File: rtl/vdma_req_ctrl.sv
module vdma_req_ctrl
  import vdma_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic [CNT_W-1:0] burst_len,
  input  logic             fetch_done,
  input  logic             bus_ack_n,
  output logic             bus_req_n
);

  localparam int XW = CNT_W + 1;

  sched_st_e        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic [XW-1:0]    cnt_next;
  logic             last_fetch;

  always_comb begin
    cnt_next   = {1'b0, cnt_q} + XW'(1);
    last_fetch = (cnt_next >= {1'b0, burst_len});
  end

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    unique case (st_q)
      ST_IDLE: if (trig) st_d = ST_WAIT;
      ST_WAIT: if (!bus_ack_n) begin
        st_d   = ST_OWN;
        cnt_d  = '0;
        cnt_en = 1'b1;
      end
      ST_OWN: if (fetch_done) begin
        cnt_en = 1'b1;
        if (last_fetch) begin
          st_d  = ST_DROP;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_next[CNT_W-1:0];
        end
      end
      ST_DROP: if (bus_ack_n) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_comb bus_req_n = !((st_q == ST_WAIT) || (st_q == ST_OWN));

  // counter only advances while the bus is owned
  assert_cnt_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_OWN) |-> (cnt_q == '0));

  // request is only released by a counted fetch
  assert_release_by_fetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req_n) |-> $past(fetch_done));

endmodule

// File: rtl/vdma_addr_mux.sv
module vdma_addr_mux #(
  parameter int LO_W = 12,
  parameter int HI_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               upper_wr,
  input  logic [HI_W-1:0]    upper_din,
  input  logic               ack_hi,
  input  logic               ack_lo_n,
  input  logic [LO_W-1:0]    ctrl_addr,
  output logic [LO_W+HI_W-1:0] dma_addr
);

  logic [HI_W-1:0] page_q, page_d;
  logic [LO_W-1:0] lo_part;
  logic [HI_W-1:0] hi_part;

  always_comb begin
    page_d  = upper_din;
    lo_part = ack_hi    ? ctrl_addr : '0;
    hi_part = !ack_lo_n ? page_q    : '0;
    dma_addr = {hi_part, lo_part};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        page_q <= '0;
    else if (upper_wr) page_q <= page_d;
  end

  assert_page_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(upper_wr) |-> $stable(page_q));

endmodule

// File: rtl/vdma_bus_sched.sv
module vdma_bus_sched #(
  parameter int LINE_W = 4,
  parameter int LO_W   = 12,
  parameter int HI_W   = 4,
  parameter int CNT_W  = 8,
  parameter int LINE_A = 6,
  parameter int LINE_B = 14
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [LINE_W-1:0]      scan_line,
  input  logic [CNT_W-1:0]       burst_len,
  input  logic                   fetch_done,
  input  logic                   bus_ack_n,
  input  logic [LO_W-1:0]        ctrl_addr,
  input  logic                   upper_wr,
  input  logic [HI_W-1:0]        upper_din,
  output logic                   bus_req_n,
  output logic                   ack_hi,
  output logic                   ack_lo_n,
  output logic                   recirc,
  output logic [LO_W+HI_W-1:0]   dma_addr
);

  logic [1:0] rst_sync_q;
  logic       rst_s;
  logic       trig;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  always_comb rst_s = rst_sync_q[1];

  always_comb begin
    ack_hi   = !bus_ack_n;
    ack_lo_n = bus_ack_n;
    recirc   = bus_ack_n;
  end

  vdma_line_trig #(
    .LINE_W(LINE_W), .LINE_A(LINE_A), .LINE_B(LINE_B)
  ) u_trig (
    .clk(clk), .rst_n(rst_s), .scan_line(scan_line), .trig(trig)
  );

  vdma_req_ctrl #(.CNT_W(CNT_W)) u_req (
    .clk(clk), .rst_n(rst_s), .trig(trig), .burst_len(burst_len),
    .fetch_done(fetch_done), .bus_ack_n(bus_ack_n), .bus_req_n(bus_req_n)
  );

  vdma_addr_mux #(.LO_W(LO_W), .HI_W(HI_W)) u_addr (
    .clk(clk), .rst_n(rst_s), .upper_wr(upper_wr), .upper_din(upper_din),
    .ack_hi(ack_hi), .ack_lo_n(ack_lo_n), .ctrl_addr(ctrl_addr),
    .dma_addr(dma_addr)
  );

  // a request only begins after a line trigger
  assert_req_from_trig_R2: assert property (@(posedge clk) disable iff (!rst_s)
    $fell(bus_req_n) |-> $past(trig));

  // no new request while the previous grant is still held
  assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rst_s)
    $fell(bus_req_n) |-> $past(bus_ack_n));

  // address bits are never driven without a grant
  assert_addr_idle_R5: assert property (@(posedge clk) disable iff (!rst_s)
    bus_ack_n |-> (dma_addr == '0));

endmodule

// File: tb/sim_vdma_bus_sched.sv
module sim_vdma_bus_sched;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  scan_line;
  logic [7:0]  burst_len;
  logic        fetch_done;
  logic        bus_ack_n;
  logic [11:0] ctrl_addr;
  logic        upper_wr;
  logic [3:0]  upper_din;
  logic        bus_req_n, ack_hi, ack_lo_n, recirc;
  logic [15:0] dma_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  vdma_bus_sched u0 (
    .clk(clk), .rst_n(rst_n), .scan_line(scan_line), .burst_len(burst_len),
    .fetch_done(fetch_done), .bus_ack_n(bus_ack_n), .ctrl_addr(ctrl_addr),
    .upper_wr(upper_wr), .upper_din(upper_din), .bus_req_n(bus_req_n),
    .ack_hi(ack_hi), .ack_lo_n(ack_lo_n), .recirc(recirc), .dma_addr(dma_addr)
  );

  // ack_n | ctrl | page | exp addr | exp ack_hi | exp recirc
  localparam logic [34:0] VEC [6] = '{
    {1'b1, 12'hABC, 4'h5, 16'h0000, 1'b0, 1'b1},
    {1'b0, 12'hABC, 4'h5, 16'h5ABC, 1'b1, 1'b0},
    {1'b0, 12'h123, 4'hF, 16'hF123, 1'b1, 1'b0},
    {1'b1, 12'h123, 4'hF, 16'h0000, 1'b0, 1'b1},
    {1'b0, 12'hFFF, 4'h0, 16'h0FFF, 1'b1, 1'b0},
    {1'b0, 12'h000, 4'h9, 16'h9000, 1'b1, 1'b0}
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; scan_line = 4'd0; burst_len = 8'd3; fetch_done = 1'b0;
    bus_ack_n = 1'b1; ctrl_addr = 12'h345; upper_wr = 1'b0; upper_din = 4'h0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();

    // R1: reset state
    chk("R1 req_n", {31'b0, bus_req_n}, 32'd1);
    bus_ack_n = 1'b0; #1;
    chk("R1 page zero", {16'b0, dma_addr}, 32'h0345);
    bus_ack_n = 1'b1; step();

    // vector table: R4 R5 R6 R7
    for (int i = 0; i < 6; i++) begin
      upper_din = VEC[i][21:18];
      upper_wr  = 1'b1;
      step();
      upper_wr  = 1'b0;
      bus_ack_n = VEC[i][34];
      ctrl_addr = VEC[i][33:22];
      #1;
      chk("R5 R6 dma_addr", {16'b0, dma_addr}, {16'b0, VEC[i][17:2]});
      chk("R4 ack_hi", {31'b0, ack_hi}, {31'b0, VEC[i][1]});
      chk("R4 ack_lo_n", {31'b0, ack_lo_n}, {31'b0, VEC[i][34]});
      chk("R7 recirc", {31'b0, recirc}, {31'b0, VEC[i][0]});
      step();
    end
    bus_ack_n = 1'b1; step();

    // R3: non-trigger line
    scan_line = 4'd5; step();
    chk("R3 line5 no req", {31'b0, bus_req_n}, 32'd1);

    // R2: entering line 6
    scan_line = 4'd6; step();
    chk("R2 line6 req", {31'b0, bus_req_n}, 32'd0);

    // R9: fetch before grant must not count
    fetch_done = 1'b1; step(); fetch_done = 1'b0; step();
    // R10: re-entering 6 while pending adds nothing
    scan_line = 4'd7; step(); scan_line = 4'd6; step();
    chk("R10 pending req", {31'b0, bus_req_n}, 32'd0);

    bus_ack_n = 1'b0; step();
    chk("R8 held on grant", {31'b0, bus_req_n}, 32'd0);
    chk("R7 grant recirc", {31'b0, recirc}, 32'd0);
    for (int k = 0; k < 2; k++) begin
      fetch_done = 1'b1; step(); fetch_done = 1'b0; step();
    end
    chk("R9 early fetch ignored", {31'b0, bus_req_n}, 32'd0);
    fetch_done = 1'b1; step(); fetch_done = 1'b0;
    chk("R8 release after burst", {31'b0, bus_req_n}, 32'd1);

    // R10: trigger while ack still held after release
    scan_line = 4'd14; step(); step();
    chk("R10 dropped trigger", {31'b0, bus_req_n}, 32'd1);
    bus_ack_n = 1'b1; step(); step();
    // R3: line 14 held across return to idle
    repeat (5) step();
    chk("R3 held line no retrigger", {31'b0, bus_req_n}, 32'd1);

    scan_line = 4'd15; step();
    chk("R3 line15 no req", {31'b0, bus_req_n}, 32'd1);
    scan_line = 4'd14; step();
    chk("R2 line14 req", {31'b0, bus_req_n}, 32'd0);

    // R8: zero burst acts as one
    burst_len = 8'd0;
    bus_ack_n = 1'b0; step();
    chk("R8 zero burst held", {31'b0, bus_req_n}, 32'd0);
    fetch_done = 1'b1; step(); fetch_done = 1'b0;
    chk("R8 zero burst release", {31'b0, bus_req_n}, 32'd1);
    bus_ack_n = 1'b1; step(); step();
    chk("R8 idle after burst", {31'b0, bus_req_n}, 32'd1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule